// File: doc/BRIEF.md
# Flow-through synchronous burst SRAM

This block is a synthesizable behavioural model of a synchronous burst static memory whose read path is flow-through. Each word holds two 9-bit lanes. Address, write data, the three chip selects, the write controls and the burst controls are all captured on the rising clock edge. Read data comes straight from the array at the captured address. It appears in the same cycle as the edge that started the access. An asynchronous output-drive enable gates it.

An access starts from one of two address-load strobes. The processor-side strobe always begins a read. The controller-side strobe begins a read or a write, as the write controls select. After an access has started, the advance input steps a 2-bit burst counter, and the order of the steps is either interleaved or linear. When advance is held, the current address is reused. The three chip selects only matter on a cycle that loads an address.

An asynchronous snooze input freezes the device. While it is high, the device is deselected and its contents are kept. The bidirectional data bus is split into a write-data input, a read-data output and a drive-enable output.

Top module: `burst_sram_ft`

## Requirements
- R1: A synchronous reset leaves the device deselected, with `dout_en` low.
- R2: When `ld_cpu_n` and `sel_n` are both low and the secondary selects are active (`sel_hi` high, `sel_lo_n` low), the address on `addr` is loaded and a read of that address is done. The write controls are ignored on that cycle, so nothing is written.
- R3: While `sel_n` is high, `ld_cpu_n` is ignored. The cycle is then decoded from `ld_ctl_n` and the burst state, so an active burst continues.
- R4: When `ld_cpu_n` and `sel_n` are low but `sel_hi` is low or `sel_lo_n` is high, the device is deselected and the bus is not driven.
- R5: When `ld_ctl_n` is low and `ld_cpu_n` is not taking effect, the outcome depends on the selects. If all three selects are active, the address is loaded and a read or write is done there. Otherwise the device is deselected.
- R6: On cycles where neither strobe takes effect, the selects are ignored. An active device keeps running its burst, and a deselected device stays deselected.
- R7: When `wr_all_n` is low, both lanes are written. Otherwise, when `byte_wr_n` is low, each lane whose `lane_we_n` bit is low is written (bit 0 is data bits 8:0, bit 1 is bits 17:9). When `byte_wr_n` is high and `wr_all_n` is high, the cycle is a read.
- R8: After a read started by `ld_cpu_n`, the next edge can write to the loaded address. This happens when that edge has both strobes high, `step_n` high and the write controls asserted.
- R9: With `step_n` low on an active cycle with no strobe, the 2-bit burst count advances and wraps after four steps, and the upper address bits stay fixed. With `linear_burst` = 0, the low two address bits are the loaded bits XOR the count. With `linear_burst` = 1, they are the loaded bits plus the count, modulo 4.
- R10: With `step_n` high on an active cycle with no strobe, the access uses the current burst address again.
- R11: `dout_en` is high only when the last edge performed a read and `drv_en_n` is low. A write or a deselect leaves `dout_en` low until the next read cycle.
- R12: While `snooze` is high, all other inputs are ignored. The device is deselected, `dout_en` is low and no location is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| snooze | input | 1 | Asynchronous freeze and deselect, active high |
| linear_burst | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| ld_cpu_n | input | 1 | Processor-side address load strobe, active low, read only |
| ld_ctl_n | input | 1 | Controller-side address load strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel_lo_n | input | 1 | Secondary chip select, active low |
| wr_all_n | input | 1 | Write both lanes, active low |
| byte_wr_n | input | 1 | Enables the lane write selects, active low |
| lane_we_n | input | NBYTES | Per-lane write selects, active low |
| drv_en_n | input | 1 | Asynchronous read-data drive enable, active low |
| din | input | DW | Write data |
| dout | output | DW | Read data from the current read address |
| dout_en | output | 1 | High when `dout` should be driven onto the bus |

## Verification
The bench aims at the cycle that follows a processor-side load. A design that dropped that write, or applied it at an advanced address, would return the old word on the readback. It also drives the processor strobe with the primary select high, and changes the secondary selects in the middle of a burst. A design that sampled the selects on those cycles would break off the burst or move it. The bench runs both burst orders from unaligned start addresses through a full wrap, and tries a write under snooze. A wrong XOR-versus-add choice shows up as the wrong word, and a leaky snooze shows up as a corrupted location.

// File: rtl/burst_sram_ft.sv
module burst_sram_ft #(
  parameter int DEPTH  = 1024,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snooze,
  input  logic              linear_burst,
  input  logic [AW-1:0]     addr,
  input  logic              ld_cpu_n,
  input  logic              ld_ctl_n,
  input  logic              step_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              wr_all_n,
  input  logic              byte_wr_n,
  input  logic [NBYTES-1:0] lane_we_n,
  input  logic              drv_en_n,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              dout_en
);

  logic [DW-1:0] mem [DEPTH];

  logic          active_q, rd_q;
  logic [AW-1:0] base_q, cur_q;
  logic [1:0]    cnt_q;

  logic              sec_ok, cpu_ld, ctl_ld, ctl_ok, cont;
  logic              load, deselect, do_access, do_write;
  logic [NBYTES-1:0] wmask;
  logic [1:0]        cnt_nx, lo_nx;
  logic [AW-1:0]     op_addr;

  assign sec_ok = sel_hi && !sel_lo_n;
  assign cpu_ld = !ld_cpu_n && !sel_n;
  assign ctl_ld = !cpu_ld && !ld_ctl_n;
  assign ctl_ok = !sel_n && sec_ok;
  assign cont   = !cpu_ld && ld_ctl_n && active_q;

  assign load     = cpu_ld || (ctl_ld && ctl_ok);
  assign deselect = (cpu_ld && !sec_ok) || (ctl_ld && !ctl_ok);

  assign wmask = !wr_all_n  ? {NBYTES{1'b1}} :
                 !byte_wr_n ? ~lane_we_n : {NBYTES{1'b0}};

  assign cnt_nx  = step_n ? cnt_q : cnt_q + 2'd1;
  assign lo_nx   = linear_burst ? base_q[1:0] + cnt_nx : base_q[1:0] ^ cnt_nx;
  assign op_addr = load ? addr : {base_q[AW-1:2], lo_nx};

  assign do_access = (cpu_ld && sec_ok) || (ctl_ld && ctl_ok) || cont;
  assign do_write  = do_access && !cpu_ld && (|wmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      cnt_q    <= 2'd0;
      base_q   <= '0;
      cur_q    <= '0;
    end else if (snooze) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      if (load) begin
        base_q <= addr;
        cnt_q  <= 2'd0;
      end else if (cont) begin
        cnt_q <= cnt_nx;
      end
      if (deselect)  active_q <= 1'b0;
      else if (load) active_q <= 1'b1;
      rd_q <= do_access && !do_write;
      if (do_access) cur_q <= op_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && !snooze && do_write)
      for (int b = 0; b < NBYTES; b++)
        if (wmask[b]) mem[op_addr][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
  end

  assign dout    = mem[cur_q];
  assign dout_en = rd_q && !drv_en_n && !snooze;

  a_r12_snooze_deselects: assert property (@(posedge clk) disable iff (rst)
    snooze |=> (!rd_q && !active_q));

  a_r11_write_hides_bus: assert property (@(posedge clk) disable iff (rst)
    (!snooze && do_write) |=> !rd_q);

  a_r5_ctl_deselect: assert property (@(posedge clk) disable iff (rst)
    (!snooze && !ld_ctl_n && sel_n) |=> !active_q);

  a_r6_selects_ignored: assert property (@(posedge clk) disable iff (rst)
    (!snooze && ld_cpu_n && ld_ctl_n && active_q) |=> active_q);

  a_r10_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    (!snooze && ld_cpu_n && ld_ctl_n && active_q && step_n) |=> ($stable(cnt_q) && $stable(base_q)));

  a_r9_advance_steps: assert property (@(posedge clk) disable iff (rst)
    (!snooze && ld_cpu_n && ld_ctl_n && active_q && !step_n) |=> (cnt_q == $past(cnt_q) + 2'd1));

endmodule

// File: tb/burst_sram_ft_tb.sv
`timescale 1ns/1ps
module burst_sram_ft_tb;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst, snooze, linear_burst;
  logic [9:0]  addr;
  logic        ld_cpu_n, ld_ctl_n, step_n, sel_n, sel_hi, sel_lo_n;
  logic        wr_all_n, byte_wr_n, drv_en_n;
  logic [1:0]  lane_we_n;
  logic [17:0] din, dout;
  logic        dout_en;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  burst_sram_ft u_dut (
    .clk(clk), .rst(rst), .snooze(snooze), .linear_burst(linear_burst), .addr(addr),
    .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .step_n(step_n), .sel_n(sel_n),
    .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n),
    .lane_we_n(lane_we_n), .drv_en_n(drv_en_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // behavioural reference model
  logic [17:0] ref_mem   [DEPTH];
  logic [1:0]  ref_known [DEPTH];
  logic        m_act = 1'b0, m_rd = 1'b0, acc;
  logic [9:0]  m_base = '0, m_cur = '0, a;
  logic [1:0]  m_cnt = '0, m;

  function automatic logic [9:0] baddr(logic [9:0] b, logic [1:0] c, logic lin);
    logic [1:0] lo;
    lo = lin ? b[1:0] + c : b[1:0] ^ c;
    return {b[9:2], lo};
  endfunction

  function automatic logic [17:0] pat(int v);
    return 18'((v * 1237 + 91) % 262144);
  endfunction

  initial for (int i = 0; i < DEPTH; i++) ref_known[i] = 2'b00;

  always @(posedge clk) begin
    if (rst || snooze) begin
      m_act = 1'b0;
      m_rd  = 1'b0;
    end else begin
      m   = !wr_all_n ? 2'b11 : (!byte_wr_n ? ~lane_we_n : 2'b00);
      acc = 1'b0;
      if (!ld_cpu_n && !sel_n) begin
        m_base = addr; m_cnt = 2'd0; m = 2'b00;
        if (sel_hi && !sel_lo_n) begin m_act = 1'b1; acc = 1'b1; end
        else m_act = 1'b0;
      end else if (!ld_ctl_n) begin
        if (!sel_n && sel_hi && !sel_lo_n) begin
          m_base = addr; m_cnt = 2'd0; m_act = 1'b1; acc = 1'b1;
        end else m_act = 1'b0;
      end else if (m_act) begin
        if (!step_n) m_cnt = m_cnt + 2'd1;
        acc = 1'b1;
      end
      if (acc) begin
        a = baddr(m_base, m_cnt, linear_burst);
        if (m != 2'b00) begin
          if (m[0]) ref_mem[a][8:0]  = din[8:0];
          if (m[1]) ref_mem[a][17:9] = din[17:9];
          ref_known[a] = ref_known[a] | m;
          m_rd = 1'b0;
        end else begin
          m_rd = 1'b1;
          m_cur = a;
        end
      end else m_rd = 1'b0;
    end
  end

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic exp_en;
      exp_en = m_rd && !drv_en_n && !snooze;
      checks++;
      if (dout_en !== exp_en) begin
        errors++;
        $display("FAIL %s model: dout_en=%0b expected %0b", cur_req, dout_en, exp_en);
      end else if (exp_en && ref_known[m_cur] == 2'b11 && dout !== ref_mem[m_cur]) begin
        errors++;
        $display("FAIL %s model: dout=%h expected %h", cur_req, dout, ref_mem[m_cur]);
      end
    end
  end

  task automatic chk_en(string req, logic exp);
    checks++;
    if (dout_en !== exp) begin
      errors++;
      $display("FAIL %s: dout_en=%0b expected %0b", req, dout_en, exp);
    end
  endtask

  task automatic chk_rd(string req, logic [17:0] exp);
    chk_en(req, 1'b1);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected %h", req, dout, exp);
    end
  endtask

  task automatic idle();
    ld_cpu_n = 1; ld_ctl_n = 1; step_n = 1; sel_n = 0; sel_hi = 1; sel_lo_n = 0;
    wr_all_n = 1; byte_wr_n = 1; lane_we_n = 2'b11; addr = '0; din = '0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic ctl_wr(int ad, logic [17:0] d, logic [1:0] mask, bit use_all);
    ld_ctl_n = 0; addr = 10'(ad); din = d;
    if (use_all) wr_all_n = 0;
    else begin byte_wr_n = 0; lane_we_n = ~mask; end
    step();
  endtask

  task automatic ctl_rd(int ad);
    ld_ctl_n = 0; addr = 10'(ad); step();
  endtask

  task automatic adv();
    step_n = 0; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst = 1; snooze = 0; linear_burst = 0; drv_en_n = 0; idle();
    repeat (3) step();
    chk_en("R1", 1'b0);
    rst = 0;
    step();
    chk_en("R1", 1'b0);

    cur_req = "R7";
    for (int i = 0; i < 64; i++) ctl_wr(i, pat(i), 2'b11, (i % 2) == 1);
    chk_en("R11", 1'b0);

    cur_req = "R5";
    ctl_rd(12); chk_rd("R5", pat(12));

    cur_req = "R2";
    ld_cpu_n = 0; addr = 10'd13; wr_all_n = 0; din = 18'h0; step();
    chk_rd("R2", pat(13));
    ctl_rd(13); chk_rd("R2", pat(13));

    cur_req = "R3";
    ctl_rd(8); chk_rd("R3", pat(8));
    ld_cpu_n = 0; sel_n = 1; addr = 10'd50; step_n = 0; step();
    chk_rd("R3", pat(9));
    cur_req = "R6";
    sel_hi = 0; sel_lo_n = 1; step_n = 0; step();
    chk_rd("R6", pat(10));
    cur_req = "R10";
    step(); chk_rd("R10", pat(10));
    cur_req = "R11";
    drv_en_n = 1; #0.5; chk_en("R11", 1'b0);
    drv_en_n = 0; #0.5; chk_rd("R11", pat(10));
    cur_req = "R9";
    adv(); chk_rd("R9", pat(11));
    adv(); chk_rd("R9", pat(8));
    cur_req = "R11";
    wr_all_n = 0; din = 18'h2AAAA; step();
    chk_en("R11", 1'b0);
    step(); chk_rd("R7", 18'h2AAAA);

    cur_req = "R9";
    linear_burst = 1;
    ctl_rd(5); chk_rd("R9", pat(5));
    adv(); chk_rd("R9", pat(6));
    adv(); chk_rd("R9", pat(7));
    adv(); chk_rd("R9", pat(4));
    adv(); chk_rd("R9", pat(5));
    linear_burst = 0;
    ctl_rd(6); chk_rd("R9", pat(6));
    adv(); chk_rd("R9", pat(7));
    adv(); chk_rd("R9", pat(4));
    adv(); chk_rd("R9", pat(5));
    adv(); chk_rd("R9", pat(6));

    cur_req = "R7";
    ctl_wr(20, 18'h3FFFF, 2'b11, 1'b1);
    ctl_wr(20, 18'h0, 2'b01, 1'b0);
    ctl_rd(20); chk_rd("R7", 18'h3FE00);
    ld_ctl_n = 0; addr = 10'd20; byte_wr_n = 1; lane_we_n = 2'b00; din = 18'h0; step();
    chk_rd("R7", 18'h3FE00);
    ld_ctl_n = 0; addr = 10'd20; wr_all_n = 0; byte_wr_n = 1; lane_we_n = 2'b11; din = 18'h12345; step();
    ctl_rd(20); chk_rd("R7", 18'h12345);

    cur_req = "R8";
    ld_cpu_n = 0; addr = 10'd30; step();
    chk_rd("R8", pat(30));
    wr_all_n = 0; din = 18'h0ABCD; step();
    chk_en("R8", 1'b0);
    ctl_rd(30); chk_rd("R8", 18'h0ABCD);

    cur_req = "R4";
    ctl_rd(31); chk_rd("R4", pat(31));
    ld_cpu_n = 0; addr = 10'd31; sel_hi = 0; step();
    chk_en("R4", 1'b0);
    step_n = 0; step();
    chk_en("R6", 1'b0);

    cur_req = "R5";
    ctl_rd(32); chk_rd("R5", pat(32));
    ld_ctl_n = 0; sel_n = 1; addr = 10'd33; step();
    chk_en("R5", 1'b0);
    step(); chk_en("R5", 1'b0);

    cur_req = "R12";
    ctl_rd(40); chk_rd("R12", pat(40));
    snooze = 1; #0.5; chk_en("R12", 1'b0);
    ld_ctl_n = 0; addr = 10'd40; wr_all_n = 0; din = 18'h15555; step();
    chk_en("R12", 1'b0);
    snooze = 0; step();
    chk_en("R12", 1'b0);
    ctl_rd(40); chk_rd("R12", pat(40));
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule